// File: doc/BRIEF.md
# I2C Memory-Transfer Sequencer

This block runs one complete I2C memory-style transfer by issuing a series of byte-level commands to an I2C master engine that sits beside it. One start pulse carries the job: a 7-bit chip address, an internal address of zero to four bytes, a byte count and a mode (write, read or probe). The sequencer builds the START, address, data and STOP commands in order, sends write bytes pulled from an input stream, and delivers read bytes on an output stream.

After every command the sequencer polls the master's completion flag at a fixed interval. When the flag rises, it compares the reported status code with the code the step should produce. A wrong code or a flag that never rises ends the data phase at once. STOP is always issued, and the job ends with a one-cycle done pulse and a 32-bit error word. The word is zero on success. Otherwise it holds an error class, the last control value written, the last status read and the status that was expected.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, busy, done, mCmdStb, wrTake and rdValid are low and errWord is zero.
- R2: A read issues START (mOp 0, control 0x60, expected status 0x08), then the write-direction device byte {chip,0} (mOp 1, control 0x40, expected 0x18), then the internal address bytes most significant first (expected 0x28 each), then a repeated START (control 0x60, expected 0x10) with no STOP before it, then the device byte {chip,1} (expected 0x40).
- R3: In a read, every received byte is requested with mOp 2 and control 0x44 (acknowledge, expected 0x50), except the last, which uses control 0x40 (no acknowledge, expected 0x58). Each accepted byte appears on rdData with a one-cycle rdValid.
- R4: A write issues START, {chip,0}, the address bytes, and then one mOp 1 command per data byte (expected 0x28). Each data byte is taken from wrData in the same cycle as a wrTake pulse.
- R5: A probe (mode 2 or 3) issues START, the device byte {chip,1}, and one receive with control 0x40, then STOP. It produces no rdValid.
- R6: When a step's status differs from the expected code, errWord becomes {8'h01, last control, received status, expected status}, and no further address or data command is issued.
- R7: When the flag has not risen after MAX_POLLS polls taken every POLL_DIV cycles, errWord becomes {8'h02, last control, current status, expected status}. With the default timing of the checks, the STOP command follows the hung command by exactly MAX_POLLS*POLL_DIV+1 cycles.
- R8: Every job ends with a STOP command (mOp 3, control 0x50), whether it succeeded or failed, before done is asserted.
- R9: If the status does not reach idle (0xF8) within MAX_POLLS polls after STOP, errWord becomes {8'h02, 0x50, current status, 0xF8}, but only when no earlier error is held. An earlier error word is kept unchanged.
- R10: done is a one-cycle pulse per job, and errWord holds until the next job starts. A goStb pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| goStb | input | 1 | Start-of-job pulse |
| modeSel | input | 2 | 0 write, 1 read, 2 or 3 probe |
| chipAddr | input | 7 | Target device address |
| regAddr | input | 32 | Internal address, low ADDR_BYTES*8 bits |
| addrLen | input | 3 | Internal address byte count (0..4) |
| xferLen | input | 8 | Data byte count |
| wrData | input | 8 | Next byte to write |
| wrTake | output | 1 | wrData consumed this cycle |
| rdData | output | 8 | Received byte |
| rdValid | output | 1 | rdData valid pulse |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished pulse |
| errWord | output | 32 | Packed error result, zero on success |
| mCmdStb | output | 1 | Command strobe to byte master |
| mOp | output | 2 | Command kind: 0 start, 1 send, 2 receive, 3 stop |
| mCtrl | output | 8 | Control value: bit6 enable, bit5 start, bit4 stop, bit2 acknowledge |
| mTxByte | output | 8 | Byte to send |
| mFlag | input | 1 | Master step-complete flag |
| mStatus | input | 8 | Master status code |
| mRxByte | input | 8 | Byte received by master |

## Verification
A model of the byte master answers each command with the status a healthy bus would give. A read with a two-byte address and three data bytes tests direction switching and the acknowledge pattern. A read with a four-byte address separates most-significant-first ordering from any other order. A write and a probe show that the send and receive phases are chosen from the mode. Fault injection returns a wrong status at the device byte, stalls the flag on an address byte, or holds the status away from idle after STOP. These cases separate the mismatch class from the timeout class, show that the word reports the failing step's control, status and expected code, and show that a STOP timeout cannot overwrite an earlier error.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_TX    = 2'd1,
    OP_RX    = 2'd2,
    OP_STOP  = 2'd3
  } opT;

  typedef enum logic [1:0] {
    BS_DEVW = 2'd0,
    BS_DEVR = 2'd1,
    BS_ADDR = 2'd2,
    BS_DATA = 2'd3
  } byteSelT;

  // control bit positions decoded by the byte master
  localparam logic [7:0] CTL_ACK   = 8'h04;
  localparam logic [7:0] CTL_STOP  = 8'h10;
  localparam logic [7:0] CTL_START = 8'h20;
  localparam logic [7:0] CTL_EN    = 8'h40;

  // status codes reported by the byte master
  localparam logic [7:0] SC_START   = 8'h08;
  localparam logic [7:0] SC_RSTART  = 8'h10;
  localparam logic [7:0] SC_ADDR_W  = 8'h18;
  localparam logic [7:0] SC_DATA_W  = 8'h28;
  localparam logic [7:0] SC_ADDR_R  = 8'h40;
  localparam logic [7:0] SC_RX_ACK  = 8'h50;
  localparam logic [7:0] SC_RX_NAK  = 8'h58;
  localparam logic [7:0] SC_IDLE    = 8'hF8;

  localparam logic [7:0] ERR_MISMATCH = 8'h01;
  localparam logic [7:0] ERR_TIMEOUT  = 8'h02;

  typedef struct packed {
    logic latchJob;
    logic issue;
    logic decAddr;
    logic decData;
    logic setErr;
    logic errTimeout;
    logic captureRx;
  } strobeT;

endpackage

// File: rtl/i2cseq_dp.sv
module i2cseq_dp
  import i2cseq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  parameter int POLL_DIV   = 50,
  parameter int MAX_POLLS  = 1000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  stb,
  input  logic [1:0]              modeSel,
  input  logic [6:0]              chipAddr,
  input  logic [8*ADDR_BYTES-1:0] regAddr,
  input  logic [$clog2(ADDR_BYTES+1)-1:0] addrLen,
  input  logic [LEN_W-1:0]        xferLen,
  input  logic [7:0]              wrData,
  input  byteSelT                 byteSel,
  input  logic [7:0]              ctrlVal,
  input  logic [7:0]              expected,
  input  logic [7:0]              mStatus,
  input  logic [7:0]              mRxByte,
  output logic [7:0]              txByte,
  output logic                    isRead,
  output logic                    isProbe,
  output logic                    addrLeft,
  output logic                    addrLast,
  output logic                    dataLeft,
  output logic                    dataLast,
  output logic                    pollTick,
  output logic                    pollExpired,
  output logic                    errPending,
  output logic [31:0]             errWord,
  output logic [7:0]              rdData,
  output logic                    rdValid
);

  localparam int AL_W  = $clog2(ADDR_BYTES + 1);
  localparam int DIV_W = $clog2(POLL_DIV + 1);
  localparam int PC_W  = $clog2(MAX_POLLS + 1);
  localparam logic [AL_W-1:0]  ADDR_MAX  = AL_W'(ADDR_BYTES);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(POLL_DIV - 1);
  localparam logic [PC_W-1:0]  POLL_LAST = PC_W'(MAX_POLLS - 1);

  logic [6:0]              chipQ;
  logic [8*ADDR_BYTES-1:0] regAddrQ;
  logic [AL_W-1:0]         addrCnt;
  logic [LEN_W-1:0]        dataCnt;
  logic [DIV_W-1:0]        divCnt;
  logic [PC_W-1:0]         pollCnt;
  logic [7:0]              lastCtrl;
  logic [AL_W-1:0]         addrSel;
  logic [8*ADDR_BYTES-1:0] addrShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chipQ    <= '0;
      regAddrQ <= '0;
      addrCnt  <= '0;
      dataCnt  <= '0;
      isRead   <= 1'b0;
      isProbe  <= 1'b0;
    end else if (stb.latchJob) begin
      chipQ    <= chipAddr;
      regAddrQ <= regAddr;
      isProbe  <= modeSel[1];
      isRead   <= (modeSel == 2'd1);
      addrCnt  <= modeSel[1] ? '0 : ((addrLen > ADDR_MAX) ? ADDR_MAX : addrLen);
      dataCnt  <= modeSel[1] ? LEN_W'(1) : xferLen;
    end else begin
      if (stb.decAddr) addrCnt <= addrCnt - 1'b1;
      if (stb.decData) dataCnt <= dataCnt - 1'b1;
    end
  end

  assign addrLeft = (addrCnt != '0);
  assign addrLast = (addrCnt == AL_W'(1));
  assign dataLeft = (dataCnt != '0);
  assign dataLast = (dataCnt == LEN_W'(1));

  // address bytes leave most significant first
  assign addrSel   = addrCnt - 1'b1;
  assign addrShift = regAddrQ >> (8 * addrSel);

  always_comb begin
    unique case (byteSel)
      BS_DEVW: txByte = {chipQ, 1'b0};
      BS_DEVR: txByte = {chipQ, 1'b1};
      BS_ADDR: txByte = addrShift[7:0];
      default: txByte = wrData;
    endcase
  end

  // poll interval and poll budget
  always_ff @(posedge clk) begin
    if (!rstN || stb.issue) begin
      divCnt  <= '0;
      pollCnt <= '0;
    end else if (pollTick) begin
      divCnt <= '0;
      if (!pollExpired) pollCnt <= pollCnt + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign pollTick    = (divCnt == DIV_LAST);
  assign pollExpired = (pollCnt == POLL_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastCtrl <= '0;
      errWord  <= '0;
    end else begin
      if (stb.issue) lastCtrl <= ctrlVal;
      if (stb.latchJob) errWord <= '0;
      else if (stb.setErr)
        errWord <= {stb.errTimeout ? ERR_TIMEOUT : ERR_MISMATCH, lastCtrl, mStatus, expected};
    end
  end

  assign errPending = (errWord != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.captureRx;
      if (stb.captureRx) rdData <= mRxByte;
    end
  end

endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
  import i2cseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       goStb,
  input  logic       isRead,
  input  logic       isProbe,
  input  logic       addrLeft,
  input  logic       addrLast,
  input  logic       dataLeft,
  input  logic       dataLast,
  input  logic       pollTick,
  input  logic       pollExpired,
  input  logic       errPending,
  input  logic       mFlag,
  input  logic [7:0] mStatus,
  output strobeT     stb,
  output byteSelT    byteSel,
  output logic [7:0] ctrlVal,
  output logic [7:0] expected,
  output opT         cmdOp,
  output logic       cmdStb,
  output logic       wrTake,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_STOP_ISSUE, S_STOP_WAIT, S_DONE
  } stateT;

  typedef enum logic [2:0] {
    STP_START, STP_DEVW, STP_ADDR, STP_RSTART, STP_DEVR, STP_RX, STP_TX
  } stepT;

  stateT state, stateNxt;
  stepT  step, stepNxt, advStep;
  logic  advStop;
  logic  inStop;

  assign inStop = (state == S_STOP_ISSUE) || (state == S_STOP_WAIT);

  // command shape and expected status per step
  always_comb begin
    byteSel  = BS_DATA;
    cmdOp    = OP_TX;
    ctrlVal  = CTL_EN;
    expected = SC_DATA_W;
    if (inStop) begin
      cmdOp    = OP_STOP;
      ctrlVal  = CTL_EN | CTL_STOP;
      expected = SC_IDLE;
    end else begin
      unique case (step)
        STP_START:  begin cmdOp = OP_START; ctrlVal = CTL_EN | CTL_START; expected = SC_START;  end
        STP_RSTART: begin cmdOp = OP_START; ctrlVal = CTL_EN | CTL_START; expected = SC_RSTART; end
        STP_DEVW:   begin byteSel = BS_DEVW; expected = SC_ADDR_W; end
        STP_DEVR:   begin byteSel = BS_DEVR; expected = SC_ADDR_R; end
        STP_ADDR:   begin byteSel = BS_ADDR; expected = SC_DATA_W; end
        STP_RX: begin
          cmdOp    = OP_RX;
          ctrlVal  = dataLast ? CTL_EN : (CTL_EN | CTL_ACK);
          expected = dataLast ? SC_RX_NAK : SC_RX_ACK;
        end
        default:    begin byteSel = BS_DATA; expected = SC_DATA_W; end
      endcase
    end
  end

  // step that follows a successful one
  always_comb begin
    advStep = step;
    advStop = 1'b0;
    unique case (step)
      STP_START:  advStep = isProbe ? STP_DEVR : STP_DEVW;
      STP_DEVW: begin
        if (addrLeft)      advStep = STP_ADDR;
        else if (isRead)   advStep = STP_RSTART;
        else if (dataLeft) advStep = STP_TX;
        else               advStop = 1'b1;
      end
      STP_ADDR: begin
        if (!addrLast)     advStep = STP_ADDR;
        else if (isRead)   advStep = STP_RSTART;
        else if (dataLeft) advStep = STP_TX;
        else               advStop = 1'b1;
      end
      STP_RSTART: advStep = STP_DEVR;
      STP_DEVR: begin
        if (dataLeft) advStep = STP_RX;
        else          advStop = 1'b1;
      end
      default: begin
        if (dataLast) advStop = 1'b1;
      end
    endcase
  end

  always_comb begin
    stateNxt = state;
    stepNxt  = step;
    stb      = '0;
    cmdStb   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (goStb) begin
          stb.latchJob = 1'b1;
          stepNxt  = STP_START;
          stateNxt = S_ISSUE;
        end
      end
      S_ISSUE: begin
        cmdStb    = 1'b1;
        stb.issue = 1'b1;
        stateNxt  = S_WAIT;
      end
      S_WAIT: begin
        if (pollTick) begin
          if (mFlag) begin
            if (mStatus == expected) begin
              stb.decAddr   = (step == STP_ADDR);
              stb.decData   = (step == STP_RX) || (step == STP_TX);
              stb.captureRx = (step == STP_RX) && !isProbe;
              stepNxt  = advStep;
              stateNxt = advStop ? S_STOP_ISSUE : S_ISSUE;
            end else begin
              stb.setErr = 1'b1;
              stateNxt   = S_STOP_ISSUE;
            end
          end else if (pollExpired) begin
            stb.setErr     = 1'b1;
            stb.errTimeout = 1'b1;
            stateNxt       = S_STOP_ISSUE;
          end
        end
      end
      S_STOP_ISSUE: begin
        cmdStb    = 1'b1;
        stb.issue = 1'b1;
        stateNxt  = S_STOP_WAIT;
      end
      S_STOP_WAIT: begin
        if (pollTick) begin
          if (mStatus == SC_IDLE) begin
            stateNxt = S_DONE;
          end else if (pollExpired) begin
            stb.setErr     = !errPending;
            stb.errTimeout = 1'b1;
            stateNxt       = S_DONE;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= STP_START;
    end else begin
      state <= stateNxt;
      step  <= stepNxt;
    end
  end

  assign wrTake = (state == S_ISSUE) && (step == STP_TX);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_DONE);

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2cseq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  parameter int POLL_DIV   = 50,
  parameter int MAX_POLLS  = 1000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    goStb,
  input  logic [1:0]              modeSel,
  input  logic [6:0]              chipAddr,
  input  logic [8*ADDR_BYTES-1:0] regAddr,
  input  logic [$clog2(ADDR_BYTES+1)-1:0] addrLen,
  input  logic [LEN_W-1:0]        xferLen,
  input  logic [7:0]              wrData,
  output logic                    wrTake,
  output logic [7:0]              rdData,
  output logic                    rdValid,
  output logic                    busy,
  output logic                    done,
  output logic [31:0]             errWord,
  output logic                    mCmdStb,
  output logic [1:0]              mOp,
  output logic [7:0]              mCtrl,
  output logic [7:0]              mTxByte,
  input  logic                    mFlag,
  input  logic [7:0]              mStatus,
  input  logic [7:0]              mRxByte
);

  strobeT  stb;
  byteSelT byteSel;
  opT      cmdOp;
  logic [7:0] expected;
  logic isRead, isProbe, addrLeft, addrLast, dataLeft, dataLast;
  logic pollTick, pollExpired, errPending;

  i2cseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .goStb(goStb),
    .isRead(isRead), .isProbe(isProbe),
    .addrLeft(addrLeft), .addrLast(addrLast),
    .dataLeft(dataLeft), .dataLast(dataLast),
    .pollTick(pollTick), .pollExpired(pollExpired), .errPending(errPending),
    .mFlag(mFlag), .mStatus(mStatus),
    .stb(stb), .byteSel(byteSel), .ctrlVal(mCtrl), .expected(expected),
    .cmdOp(cmdOp), .cmdStb(mCmdStb), .wrTake(wrTake), .busy(busy), .done(done)
  );

  i2cseq_dp #(
    .ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W),
    .POLL_DIV(POLL_DIV), .MAX_POLLS(MAX_POLLS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .modeSel(modeSel), .chipAddr(chipAddr), .regAddr(regAddr),
    .addrLen(addrLen), .xferLen(xferLen), .wrData(wrData),
    .byteSel(byteSel), .ctrlVal(mCtrl), .expected(expected),
    .mStatus(mStatus), .mRxByte(mRxByte), .txByte(mTxByte),
    .isRead(isRead), .isProbe(isProbe),
    .addrLeft(addrLeft), .addrLast(addrLast),
    .dataLeft(dataLeft), .dataLast(dataLast),
    .pollTick(pollTick), .pollExpired(pollExpired), .errPending(errPending),
    .errWord(errWord), .rdData(rdData), .rdValid(rdValid)
  );

  assign mOp = cmdOp;

endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        wrTake,
  input logic        rdValid,
  input logic        mCmdStb,
  input logic [1:0]  mOp,
  input logic [7:0]  mCtrl,
  input logic [31:0] errWord
);

  logic [1:0] lastOp;

  always_ff @(posedge clk) begin
    if (!rstN) lastOp <= 2'd0;
    else if (mCmdStb) lastOp <= mOp;
  end

  AST_START_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (mCmdStb && mOp == 2'd0) |-> (mCtrl == 8'h60)); // R2

  AST_RX_ACK_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (mCmdStb && mOp == 2'd2) |-> (mCtrl == 8'h44 || mCtrl == 8'h40)); // R3

  AST_TAKE_WITH_SEND: assert property (@(posedge clk) disable iff (!rstN)
    wrTake |-> (mCmdStb && mOp == 2'd1)); // R4

  AST_ERR_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errWord[31:24] <= 8'd2)); // R6

  AST_STOP_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (mCmdStb && mOp == 2'd3) |-> (mCtrl == 8'h50)); // R8

  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (lastOp == 2'd3)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mCmdStb && !rdValid)); // R10

endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .wrTake(wrTake),
  .rdValid(rdValid), .mCmdStb(mCmdStb), .mOp(mOp), .mCtrl(mCtrl),
  .errWord(errWord)
);

// File: tb/i2c_xfer_seq_tb.sv
`timescale 1ns/1ps
module i2c_xfer_seq_tb;

  localparam int POLL_DIV  = 4;
  localparam int MAX_POLLS = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        goStb = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [6:0]  chipAddr = '0;
  logic [31:0] regAddr = '0;
  logic [2:0]  addrLen = '0;
  logic [7:0]  xferLen = '0;
  logic [7:0]  wrData;
  logic        wrTake, rdValid, busy, done, mCmdStb;
  logic [7:0]  rdData, mCtrl, mTxByte;
  logic [1:0]  mOp;
  logic [31:0] errWord;
  logic        mFlag;
  logic [7:0]  mStatus, mRxByte;

  i2c_xfer_seq #(.POLL_DIV(POLL_DIV), .MAX_POLLS(MAX_POLLS)) u_dut (
    .clk(clk), .rstN(rstN), .goStb(goStb), .modeSel(modeSel),
    .chipAddr(chipAddr), .regAddr(regAddr), .addrLen(addrLen), .xferLen(xferLen),
    .wrData(wrData), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .busy(busy), .done(done), .errWord(errWord),
    .mCmdStb(mCmdStb), .mOp(mOp), .mCtrl(mCtrl), .mTxByte(mTxByte),
    .mFlag(mFlag), .mStatus(mStatus), .mRxByte(mRxByte)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // byte-master model knobs and logs
  int         faultIdx = -1;
  int         faultKind = 0;   // 1 wrong status, 2 hang flag
  logic [7:0] faultSt = '0;
  bit         stopHang = 1'b0;
  int         cmdIdx = 0;
  int         rxCnt = 0;
  int         cyc = 0;
  int         logN = 0;
  logic [1:0] logOp [0:31];
  logic [7:0] logCtrl [0:31];
  logic [7:0] logByte [0:31];
  int         logCyc [0:31];
  logic [7:0] rdBuf [0:15];
  int         rdN = 0;
  int         takeN = 0;
  int         doneN = 0;
  logic [31:0] errAtDone = '0;
  logic [7:0] wrBuf [0:15];

  assign wrData = (takeN < 16) ? wrBuf[takeN] : 8'h00;

  logic       pend;
  int         dly;
  logic [7:0] respQ;
  logic       hangQ, stopQ, rxQ;
  bit         inXfer, afterStart;

  always @(posedge clk) begin
    logic [7:0] rs;
    logic       hg;
    cyc <= cyc + 1;
    if (!rstN) begin
      mFlag <= 1'b0; mStatus <= 8'hF8; mRxByte <= 8'h00;
      pend <= 1'b0; dly <= 0; respQ <= 8'hF8; hangQ <= 1'b0; stopQ <= 1'b0; rxQ <= 1'b0;
      inXfer = 1'b0; afterStart = 1'b0;
    end else if (mCmdStb) begin
      if (logN < 32) begin
        logOp[logN] = mOp; logCtrl[logN] = mCtrl; logByte[logN] = mTxByte; logCyc[logN] = cyc;
      end
      logN = logN + 1;
      rs = 8'hF8;
      case (mOp)
        2'd0: begin rs = inXfer ? 8'h10 : 8'h08; inXfer = 1'b1; afterStart = 1'b1; end
        2'd1: begin rs = afterStart ? (mTxByte[0] ? 8'h40 : 8'h18) : 8'h28; afterStart = 1'b0; end
        2'd2: begin rs = mCtrl[2] ? 8'h50 : 8'h58; afterStart = 1'b0; end
        default: begin rs = 8'hF8; inXfer = 1'b0; end
      endcase
      hg = 1'b0;
      if (cmdIdx == faultIdx && faultKind == 1) rs = faultSt;
      if (cmdIdx == faultIdx && faultKind == 2) hg = 1'b1;
      if (mOp == 2'd3 && stopHang) hg = 1'b1;
      cmdIdx = cmdIdx + 1;
      mFlag <= 1'b0; pend <= 1'b1; dly <= 3;
      respQ <= rs; hangQ <= hg; stopQ <= (mOp == 2'd3); rxQ <= (mOp == 2'd2);
    end else if (pend) begin
      if (dly > 1) dly <= dly - 1;
      else begin
        pend <= 1'b0;
        if (!hangQ) begin
          mStatus <= respQ;
          if (!stopQ) mFlag <= 1'b1;
          if (rxQ) begin mRxByte <= 8'hC0 + 8'(rxCnt); rxCnt = rxCnt + 1; end
        end
      end
    end
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        if (rdN < 16) rdBuf[rdN] = rdData;
        rdN = rdN + 1;
      end
      if (wrTake) takeN = takeN + 1;
      if (done) begin doneN = doneN + 1; errAtDone = errWord; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chkCmd(input int i, input logic [1:0] op, input logic [7:0] ctl,
                        input logic [7:0] b, input string req);
    logic [31:0] act, exp;
    act = {14'd0, logOp[i], logCtrl[i], logByte[i]};
    exp = {14'd0, op, ctl, (op == 2'd1) ? b : logByte[i]};
    chk(act == exp, req, act, exp);
  endtask

  task automatic clearModel();
    faultIdx = -1; faultKind = 0; stopHang = 1'b0;
    cmdIdx = 0; rxCnt = 0; logN = 0; rdN = 0; takeN = 0; doneN = 0;
  endtask

  task automatic runJob(input logic [1:0] md, input logic [6:0] chip, input logic [31:0] ra,
                        input logic [2:0] al, input logic [7:0] len, input bit extraGo);
    @(negedge clk);
    modeSel = md; chipAddr = chip; regAddr = ra; addrLen = al; xferLen = len; goStb = 1'b1;
    @(negedge clk);
    goStb = 1'b0;
    if (extraGo) begin
      repeat (6) @(negedge clk);
      modeSel = 2'd0; chipAddr = 7'h11; goStb = 1'b1;
      @(negedge clk);
      goStb = 1'b0;
    end
    for (int k = 0; k < 20000 && doneN == 0; k++) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic tReset();
    chk(!busy && !done && !mCmdStb && !wrTake && !rdValid, "R1 idle outputs",
        {27'd0, busy, done, mCmdStb, wrTake, rdValid}, 32'd0);
    chk(errWord == 32'd0, "R1 errWord", errWord, 32'd0);
  endtask

  task automatic tRead();
    clearModel();
    runJob(2'd1, 7'h50, 32'h0000_1234, 3'd2, 8'd3, 1'b0);
    chk(logN == 10, "R2 command count", logN, 10);
    chkCmd(0, 2'd0, 8'h60, 8'h00, "R2 start");
    chkCmd(1, 2'd1, 8'h40, 8'hA0, "R2 device write byte");
    chkCmd(2, 2'd1, 8'h40, 8'h12, "R2 address high");
    chkCmd(3, 2'd1, 8'h40, 8'h34, "R2 address low");
    chkCmd(4, 2'd0, 8'h60, 8'h00, "R2 repeated start without stop");
    chkCmd(5, 2'd1, 8'h40, 8'hA1, "R2 device read byte");
    chkCmd(6, 2'd2, 8'h44, 8'h00, "R3 ack first");
    chkCmd(7, 2'd2, 8'h44, 8'h00, "R3 ack middle");
    chkCmd(8, 2'd2, 8'h40, 8'h00, "R3 nak last");
    chkCmd(9, 2'd3, 8'h50, 8'h00, "R8 stop");
    chk(rdN == 3, "R3 read byte count", rdN, 3);
    chk(rdBuf[0] == 8'hC0 && rdBuf[1] == 8'hC1 && rdBuf[2] == 8'hC2, "R3 read bytes",
        {8'd0, rdBuf[0], rdBuf[1], rdBuf[2]}, 32'h00C0C1C2);
    chk(errAtDone == 32'd0 && doneN == 1, "R10 success word and single done", errAtDone, 0);
  endtask

  task automatic tLongAddr();
    clearModel();
    runJob(2'd1, 7'h68, 32'hDEAD_BEEF, 3'd4, 8'd1, 1'b0);
    chk(logN == 10, "R2 long address count", logN, 10);
    chk({logByte[2], logByte[3], logByte[4], logByte[5]} == 32'hDEADBEEF,
        "R2 msb first order", {logByte[2], logByte[3], logByte[4], logByte[5]}, 32'hDEADBEEF);
    chkCmd(8, 2'd2, 8'h40, 8'h00, "R3 single byte nak");
  endtask

  task automatic tWrite();
    clearModel();
    wrBuf[0] = 8'h5A; wrBuf[1] = 8'hA5;
    runJob(2'd0, 7'h21, 32'h0000_0007, 3'd1, 8'd2, 1'b0);
    chk(logN == 6, "R4 command count", logN, 6);
    chkCmd(1, 2'd1, 8'h40, 8'h42, "R4 device byte");
    chkCmd(2, 2'd1, 8'h40, 8'h07, "R4 address byte");
    chkCmd(3, 2'd1, 8'h40, 8'h5A, "R4 data 0");
    chkCmd(4, 2'd1, 8'h40, 8'hA5, "R4 data 1");
    chkCmd(5, 2'd3, 8'h50, 8'h00, "R8 write stop");
    chk(takeN == 2 && errAtDone == 0, "R4 takes and success", takeN, 2);
  endtask

  task automatic tProbe();
    clearModel();
    runJob(2'd2, 7'h3C, 32'h0, 3'd0, 8'd5, 1'b0);
    chk(logN == 4, "R5 probe count", logN, 4);
    chkCmd(1, 2'd1, 8'h40, 8'h79, "R5 probe read address");
    chkCmd(2, 2'd2, 8'h40, 8'h00, "R5 probe nak");
    chk(rdN == 0 && errAtDone == 0, "R5 no read output", rdN, 0);
  endtask

  task automatic tMismatch();
    clearModel();
    faultIdx = 1; faultKind = 1; faultSt = 8'h20;
    wrBuf[0] = 8'h11;
    runJob(2'd0, 7'h21, 32'h0, 3'd1, 8'd2, 1'b0);
    chk(errAtDone == 32'h01402018, "R6 mismatch word", errAtDone, 32'h01402018);
    chk(logN == 3 && takeN == 0, "R6 no further steps", logN, 3);
    chkCmd(2, 2'd3, 8'h50, 8'h00, "R8 stop after mismatch");
  endtask

  task automatic tTimeout();
    clearModel();
    faultIdx = 2; faultKind = 2;
    runJob(2'd1, 7'h50, 32'h0000_ABCD, 3'd2, 8'd1, 1'b0);
    chk(errAtDone == 32'h02401828, "R7 timeout word", errAtDone, 32'h02401828);
    chk(logN == 4, "R7 commands before stop", logN, 4);
    chk(logCyc[3] - logCyc[2] == MAX_POLLS * POLL_DIV + 1, "R7 timeout interval",
        logCyc[3] - logCyc[2], MAX_POLLS * POLL_DIV + 1);
    chkCmd(3, 2'd3, 8'h50, 8'h00, "R8 stop after timeout");
  endtask

  task automatic tStopHang();
    clearModel();
    stopHang = 1'b1;
    runJob(2'd2, 7'h3C, 32'h0, 3'd0, 8'd0, 1'b0);
    chk(errAtDone == 32'h025058F8, "R9 stop timeout word", errAtDone, 32'h025058F8);
    clearModel();
    stopHang = 1'b1; faultIdx = 1; faultKind = 1; faultSt = 8'h48;
    runJob(2'd2, 7'h3C, 32'h0, 3'd0, 8'd0, 1'b0);
    chk(errAtDone == 32'h01404840, "R9 earlier error kept", errAtDone, 32'h01404840);
  endtask

  task automatic tBusyGo();
    clearModel();
    runJob(2'd1, 7'h50, 32'h0000_1234, 3'd2, 8'd3, 1'b1);
    chk(logN == 10 && logByte[1] == 8'hA0, "R10 go while busy ignored", logN, 10);
    chk(doneN == 1 && !busy, "R10 single done pulse", doneN, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRead();
    tLongAddr();
    tWrite();
    tProbe();
    tMismatch();
    tTimeout();
    tStopHang();
    tBusyGo();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule